// File: doc/BRIEF.md
# Ready-Gated System Clock Switch

This block picks the system clock from five sources: a fast internal RC oscillator, a slow internal RC oscillator, a fast external crystal, a slow external crystal and a PLL. Software writes the code of the source it wants. The block moves to that source only once the source's ready input is high. Ready means the oscillator has settled after its startup delay, or, for the PLL, that it has locked. A request to a source that is not yet ready is held, and it completes by itself once ready rises.

The handover has no glitches. Each source has a gate that opens and closes only on that source's falling edge. Each gate is armed through its own two-flop synchronizer, and a gate arms only after it sees every other gate closed. The status code changes only after the new gate has been seen open.

The block also keeps a register of oscillator enables. It will not turn off the source that drives the system clock, the source it is switching to, or the reference that feeds the PLL while the PLL is in use. The reference is either the fast internal RC or the fast crystal, chosen by one input.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the source in use is the fast internal RC (code 0). No switch is pending, the requested code reads 0 and only oscillator-enable bit 0 is set.
- R2: The source in use changes only to a source whose synchronized ready flag was high. A request to a source that is not ready leaves the source in use unchanged.
- R3: A request to a source that is not ready stays pending (`sw_pending` = 1, `req_src` = the requested code). It completes without further writes once that source's ready input rises.
- R4: `cur_src` names the source driving `sys_clk`. It changes only after the new source's gate is open.
- R5: `rdy_flags` bit i shows `src_rdy` bit i two `cfg_clk` rising edges after it changes.
- R6: A write to the enable register with `en_wr` sets `osc_en` to `en_data` on the next edge. Bits of protected sources are held at 1: the source in use, the switch target, and the PLL reference whenever the PLL is in use. The PLL reference is code 2 when `pll_ref_ext` = 1 and code 0 otherwise.
- R7: Source codes are 0 fast internal RC, 1 slow internal RC, 2 fast crystal, 3 slow crystal and 4 PLL. A write with a code from 5 to 7 changes neither `req_src` nor the switch state.
- R8: A new request replaces any pending one. A request for the source already in use cancels the pending switch. Whenever nothing is pending, `req_src` equals `cur_src`.
- R9: No two source gates are ever open at once, and every high pulse on `sys_clk` is exactly one high phase of a source clock.
- R10: If the target's ready flag falls before the switch completes, the block stays on (or returns to) the current source and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Control clock for the request, status and enable registers |
| rst_n | input | 1 | Synchronous active-low reset, sampled by every clock |
| src_clk | input | 5 | Source clocks, indexed by source code |
| src_rdy | input | 5 | Per-source ready (stable or locked), asynchronous |
| req_wr | input | 1 | Strobe that writes `req_code` |
| req_code | input | 3 | Requested source code |
| en_wr | input | 1 | Strobe that writes `en_data` to the enable register |
| en_data | input | 5 | Requested oscillator enables |
| pll_ref_ext | input | 1 | PLL reference: 1 fast crystal, 0 fast internal RC |
| sys_clk | output | 1 | Glitch-free system clock |
| cur_src | output | 3 | Code of the source driving `sys_clk` |
| req_src | output | 3 | Last accepted requested code |
| sw_pending | output | 1 | A switch is waiting or in progress |
| rdy_flags | output | 5 | Synchronized ready flags |
| osc_en | output | 5 | Oscillator enables, protected bits held at 1 |

## Verification
The bench targets a request held until ready appears. A design that switched early would report a dead source, and one that dropped the request would never switch. It also covers a request replaced or cancelled while pending, codes 5 to 7, and a one-cycle ready pulse that starts a switch which must then back out. A block without the back-out would report a source that is not ready. Enable writes of all zeros must leave the source in use, and the PLL's reference, switched on for either reference setting. A monitor measures every high pulse on `sys_clk`, so a handover whose gates overlapped or closed mid-phase shows up as a sliver that matches no source half-period.

// File: rtl/sysclk_pkg.sv
// Shared constants and helpers for the system clock switch.
// Assumes source codes are dense from 0 to N_SRC-1.
package sysclk_pkg;
    localparam int N_SRC  = 5;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] SRC_INT_FAST  = 3'd0;
    localparam logic [CODE_W-1:0] SRC_INT_SLOW  = 3'd1;
    localparam logic [CODE_W-1:0] SRC_XTAL_FAST = 3'd2;
    localparam logic [CODE_W-1:0] SRC_XTAL_SLOW = 3'd3;
    localparam logic [CODE_W-1:0] SRC_PLL       = 3'd4;

    // One-hot vector for a source code; all zero for an unused code.
    function automatic logic [N_SRC-1:0] code_to_oh(input logic [CODE_W-1:0] c);
        logic [N_SRC-1:0] r;
        r = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (c == CODE_W'(i)) r[i] = 1'b1;
        end
        return r;
    endfunction

    // True when the code names an existing source.
    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return c < CODE_W'(N_SRC);
    endfunction
endpackage

// File: rtl/sysclk_sync.sv
// Multi-stage synchronizer for a bus of independent level signals.
// Assumes each bit may change at any time relative to clk; there is no bus coherency.
module sysclk_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sysclk_gate_cell.sv
// Gate for one source clock. It arms when this source is wanted and every
// other gate is closed, synchronizes that decision into its own clock, and
// moves its enable only on the falling edge, so the AND gate passes whole
// high phases. Assumes the source clock runs while reset is held.
module sysclk_gate_cell #(
    parameter bit OPEN_AT_RESET = 1'b0,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic others_open,
    output logic gate_en
);
    logic arm_d;
    logic arm_s;

    assign arm_d = want & ~others_open;

    sysclk_sync #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES),
        .RST_VAL(OPEN_AT_RESET)
    ) u_arm_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (arm_d),
        .q    (arm_s)
    );

    // Change the enable while the source clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_en <= OPEN_AT_RESET;
        else        gate_en <= arm_s;
    end
endmodule

// File: rtl/sysclk_ctrl.sv
// Control logic in the cfg_clk domain: request register, pending switch,
// one-hot "want" vector for the gates, status and protected enables.
// Assumes rdy_s and ack_s are already synchronized to clk and that both
// pass through the same number of stages.
module sysclk_ctrl
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [CODE_W-1:0] req_code,
    input  logic              en_wr,
    input  logic [N_SRC-1:0]  en_data,
    input  logic              pll_ref_ext,
    input  logic [N_SRC-1:0]  rdy_s,
    input  logic [N_SRC-1:0]  ack_s,
    output logic [N_SRC-1:0]  want,
    output logic [CODE_W-1:0] cur,
    output logic [CODE_W-1:0] tgt,
    output logic              pend,
    output logic [N_SRC-1:0]  osc_en
);
    logic [N_SRC-1:0]  cur_oh;
    logic [N_SRC-1:0]  tgt_oh;
    logic              settled;
    logic              tgt_rdy;
    logic              done;
    logic [CODE_W-1:0] cur_nxt;
    logic [N_SRC-1:0]  want_nxt;
    logic [CODE_W-1:0] tgt_nxt;
    logic              pend_nxt;
    logic [N_SRC-1:0]  ref_oh;
    logic [N_SRC-1:0]  guard;
    logic [N_SRC-1:0]  in_use;

    assign cur_oh  = code_to_oh(cur);
    assign tgt_oh  = code_to_oh(tgt);
    assign settled = (ack_s == want);
    assign tgt_rdy = |(rdy_s & tgt_oh);
    assign done    = settled && pend && (want == tgt_oh) && tgt_rdy;
    assign cur_nxt = done ? tgt : cur;

    // Steer the gates only once the last handover has been seen complete.
    always_comb begin
        want_nxt = want;
        if (settled) begin
            if (pend && tgt_rdy && !done) want_nxt = tgt_oh;
            else                          want_nxt = code_to_oh(cur_nxt);
        end
    end

    // Completion clears the pending flag; a valid write then overrides it.
    always_comb begin
        tgt_nxt  = done ? cur_nxt : tgt;
        pend_nxt = done ? 1'b0 : pend;
        if (req_wr && code_valid(req_code)) begin
            tgt_nxt  = req_code;
            pend_nxt = (req_code != cur_nxt);
        end
    end

    // Sources that must stay enabled this cycle.
    always_comb begin
        ref_oh = pll_ref_ext ? code_to_oh(SRC_XTAL_FAST) : code_to_oh(SRC_INT_FAST);
        in_use = want | cur_oh;
        guard  = in_use | (in_use[SRC_PLL] ? ref_oh : '0);
    end

    // Switch state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want <= code_to_oh(SRC_INT_FAST);
            cur  <= SRC_INT_FAST;
            tgt  <= SRC_INT_FAST;
            pend <= 1'b0;
        end else begin
            want <= want_nxt;
            cur  <= cur_nxt;
            tgt  <= tgt_nxt;
            pend <= pend_nxt;
        end
    end

    // Enable register with protected bits forced on.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_en <= code_to_oh(SRC_INT_FAST);
        else        osc_en <= (en_wr ? en_data : osc_en) | guard;
    end
endmodule

// File: rtl/sysclk_switch.sv
// Top of the ready-gated system clock switch: ready and gate-state
// synchronizers, one gate cell per source and the output OR tree.
// Assumes every source clock toggles during reset, and that a source keeps
// running until its gate has closed.
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_clk,
    input  logic [N_SRC-1:0]  src_rdy,
    input  logic              req_wr,
    input  logic [CODE_W-1:0] req_code,
    input  logic              en_wr,
    input  logic [N_SRC-1:0]  en_data,
    input  logic              pll_ref_ext,
    output logic              sys_clk,
    output logic [CODE_W-1:0] cur_src,
    output logic [CODE_W-1:0] req_src,
    output logic              sw_pending,
    output logic [N_SRC-1:0]  rdy_flags,
    output logic [N_SRC-1:0]  osc_en
);
    localparam logic [N_SRC-1:0] HOME_OH = N_SRC'(1);

    logic [N_SRC-1:0] rdy_s;
    logic [N_SRC-1:0] ack_s;
    logic [N_SRC-1:0] want;
    logic [N_SRC-1:0] gate_en;
    logic [N_SRC-1:0] gated;

    sysclk_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rdy_sync (
        .clk  (cfg_clk),
        .rst_n(rst_n),
        .d    (src_rdy),
        .q    (rdy_s)
    );

    sysclk_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL(HOME_OH)) u_ack_sync (
        .clk  (cfg_clk),
        .rst_n(rst_n),
        .d    (gate_en),
        .q    (ack_s)
    );

    sysclk_ctrl u_ctrl (
        .clk        (cfg_clk),
        .rst_n      (rst_n),
        .req_wr     (req_wr),
        .req_code   (req_code),
        .en_wr      (en_wr),
        .en_data    (en_data),
        .pll_ref_ext(pll_ref_ext),
        .rdy_s      (rdy_s),
        .ack_s      (ack_s),
        .want       (want),
        .cur        (cur_src),
        .tgt        (req_src),
        .pend       (sw_pending),
        .osc_en     (osc_en)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic others;
        assign others = |(gate_en & ~(N_SRC'(1) << i));

        sysclk_gate_cell #(
            .OPEN_AT_RESET(i == 0),
            .SYNC_STAGES  (SYNC_STAGES)
        ) u_gate (
            .clk        (src_clk[i]),
            .rst_n      (rst_n),
            .want       (want[i]),
            .others_open(others),
            .gate_en    (gate_en[i])
        );

        assign gated[i] = src_clk[i] & gate_en[i];
    end

    assign sys_clk   = |gated;
    assign rdy_flags = rdy_s;
endmodule

// File: rtl/sysclk_switch_chk.sv
// Property checker for sysclk_switch, attached with bind. Samples
// everything on cfg_clk; gate states are read as level signals.
module sysclk_switch_chk
    import sysclk_pkg::*;
(
    input logic              cfg_clk,
    input logic              rst_n,
    input logic              req_wr,
    input logic [CODE_W-1:0] req_code,
    input logic [CODE_W-1:0] cur_src,
    input logic [CODE_W-1:0] req_src,
    input logic              sw_pending,
    input logic [N_SRC-1:0]  rdy_flags,
    input logic [N_SRC-1:0]  osc_en,
    input logic [N_SRC-1:0]  gate_en
);
    AST_RESET_HOME: assert property (@(posedge cfg_clk)
        !rst_n |=> (cur_src == SRC_INT_FAST) && !sw_pending); // R1

    AST_SWITCH_NEEDS_READY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> |($past(rdy_flags) & code_to_oh(cur_src))); // R2

    AST_STATUS_AFTER_OPEN: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> |(gate_en & code_to_oh(cur_src))); // R4

    AST_GUARD_IN_USE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        |(osc_en & code_to_oh(cur_src))); // R6

    AST_BAD_CODE_IGNORED: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (req_wr && !code_valid(req_code)) |=> (req_src == $past(req_src))); // R7

    AST_IDLE_MATCH: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !sw_pending |-> (req_src == cur_src)); // R8

    AST_GATES_EXCLUSIVE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(gate_en)); // R9
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_code  (req_code),
    .cur_src   (cur_src),
    .req_src   (req_src),
    .sw_pending(sw_pending),
    .rdy_flags (rdy_flags),
    .osc_en    (osc_en),
    .gate_en   (gate_en)
);

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
// Self-checking bench: five free-running source clocks, a table of switch
// vectors, then directed tests for reset, replace, cancel, ready loss,
// enable protection and a pulse-width monitor on sys_clk.
module sysclk_switch_bench;
    localparam int  SETTLE = 400;
    localparam real HALF [5] = '{6.0, 25.0, 4.0, 33.0, 3.0};

    typedef struct packed {
        logic [4:0] rdy;
        logic [2:0] code;
        logic [2:0] cur;
        logic       pend;
        logic [2:0] req;
    } vec_t;

    // rdy mask, written code, expected status, pending and request
    localparam vec_t VECS [8] = '{
        '{5'b11111, 3'd2, 3'd2, 1'b0, 3'd2},
        '{5'b11111, 3'd4, 3'd4, 1'b0, 3'd4},
        '{5'b11111, 3'd1, 3'd1, 1'b0, 3'd1},
        '{5'b11111, 3'd3, 3'd3, 1'b0, 3'd3},
        '{5'b11111, 3'd0, 3'd0, 1'b0, 3'd0},
        '{5'b11111, 3'd5, 3'd0, 1'b0, 3'd0},
        '{5'b00001, 3'd2, 3'd0, 1'b1, 3'd2},
        '{5'b00101, 3'd7, 3'd2, 1'b0, 3'd2}
    };

    logic       cfg_clk = 1'b0;
    logic       rst_n;
    logic [4:0] src_clk;
    logic [4:0] src_rdy;
    logic       req_wr;
    logic [2:0] req_code;
    logic       en_wr;
    logic [4:0] en_data;
    logic       pll_ref_ext;
    logic       sys_clk;
    logic [2:0] cur_src;
    logic [2:0] req_src;
    logic       sw_pending;
    logic [4:0] rdy_flags;
    logic [4:0] osc_en;

    int checks = 0;
    int failures = 0;
    int glitch_bad = 0;
    logic mon_on = 1'b0;
    realtime t_rise = 0.0;

    always #2 cfg_clk = ~cfg_clk;

    for (genvar g = 0; g < 5; g++) begin : g_clk
        logic ck;
        initial begin
            ck = 1'b0;
            #(0.7 * (g + 1));
            forever #(HALF[g]) ck = ~ck;
        end
        assign src_clk[g] = ck;
    end

    sysclk_switch u_sysclk_switch (
        .cfg_clk    (cfg_clk),
        .rst_n      (rst_n),
        .src_clk    (src_clk),
        .src_rdy    (src_rdy),
        .req_wr     (req_wr),
        .req_code   (req_code),
        .en_wr      (en_wr),
        .en_data    (en_data),
        .pll_ref_ext(pll_ref_ext),
        .sys_clk    (sys_clk),
        .cur_src    (cur_src),
        .req_src    (req_src),
        .sw_pending (sw_pending),
        .rdy_flags  (rdy_flags),
        .osc_en     (osc_en)
    );

    function automatic bit width_ok(input realtime w);
        for (int k = 0; k < 5; k++) begin
            if (w > HALF[k] - 0.01 && w < HALF[k] + 0.01) return 1'b1;
        end
        return 1'b0;
    endfunction

    // R9 pulse-width monitor on the switched clock
    always @(posedge sys_clk) t_rise = $realtime;
    always @(negedge sys_clk) begin
        if (mon_on && !width_ok($realtime - t_rise)) begin
            glitch_bad++;
            $display("pulse of %0.3f ns at %0t", $realtime - t_rise, $realtime);
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge cfg_clk);
    endtask

    task automatic write_req(input logic [2:0] code);
        @(negedge cfg_clk);
        req_wr = 1'b1;
        req_code = code;
        @(negedge cfg_clk);
        req_wr = 1'b0;
    endtask

    task automatic write_en(input logic [4:0] data);
        @(negedge cfg_clk);
        en_wr = 1'b1;
        en_data = data;
        @(negedge cfg_clk);
        en_wr = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge cfg_clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        src_rdy = 5'b00001;
        req_wr = 1'b0;
        req_code = '0;
        en_wr = 1'b0;
        en_data = '0;
        pll_ref_ext = 1'b0;
        cycles(100);
        rst_n = 1'b1;
        cycles(4);
        mon_on = 1'b1;

        // R1 reset state
        check("R1 cur_src", 8'(cur_src), 8'd0);
        check("R1 sw_pending", 8'(sw_pending), 8'd0);
        check("R1 req_src", 8'(req_src), 8'd0);
        check("R1 osc_en", 8'(osc_en), 8'h01);

        // R2 R3 R7 table of switch vectors
        for (int v = 0; v < 8; v++) begin
            @(negedge cfg_clk);
            src_rdy = VECS[v].rdy;
            write_req(VECS[v].code);
            cycles(SETTLE);
            check($sformatf("R7 R2 vec%0d cur_src", v), 8'(cur_src), 8'(VECS[v].cur));
            check($sformatf("R3 vec%0d sw_pending", v), 8'(sw_pending), 8'(VECS[v].pend));
            check($sformatf("R7 vec%0d req_src", v), 8'(req_src), 8'(VECS[v].req));
        end

        // R5 ready flags follow inputs after synchronization
        src_rdy = 5'b01101;
        cycles(3);
        check("R5 rdy_flags", 8'(rdy_flags), 8'h0D);

        // R8 replace: pending 1 overwritten by 3, which is ready
        src_rdy = 5'b00101;
        write_req(3'd1);
        cycles(20);
        check("R3 pending on not-ready", 8'(sw_pending), 8'd1);
        write_req(3'd3);
        check("R8 replaced req_src", 8'(req_src), 8'd3);
        src_rdy = 5'b01101;
        cycles(SETTLE);
        check("R8 replace cur_src", 8'(cur_src), 8'd3);

        // R8 cancel: pending 4 withdrawn by asking for the current source
        write_req(3'd4);
        cycles(20);
        check("R8 cancel setup pending", 8'(sw_pending), 8'd1);
        write_req(3'd3);
        check("R8 cancel sw_pending", 8'(sw_pending), 8'd0);
        @(negedge cfg_clk);
        src_rdy = 5'b11101;
        cycles(SETTLE);
        check("R8 cancel cur_src", 8'(cur_src), 8'd3);

        // R10 ready pulse starts a switch that must back out
        src_rdy = 5'b11001;
        write_req(3'd1);
        cycles(10);
        src_rdy = 5'b11011;
        @(negedge cfg_clk);
        src_rdy = 5'b11001;
        cycles(SETTLE);
        check("R10 cur_src kept", 8'(cur_src), 8'd3);
        check("R10 still pending", 8'(sw_pending), 8'd1);
        check("R10 req_src kept", 8'(req_src), 8'd1);
        src_rdy = 5'b11011;
        cycles(SETTLE);
        check("R3 late ready completes", 8'(cur_src), 8'd1);

        // R6 enable protection
        write_en(5'b00000);
        check("R6 guard direct", 8'(osc_en), 8'h02);
        write_en(5'b11111);
        check("R6 plain write", 8'(osc_en), 8'h1F);
        pll_ref_ext = 1'b1;
        write_req(3'd4);
        cycles(SETTLE);
        check("R4 on pll", 8'(cur_src), 8'd4);
        write_en(5'b00000);
        check("R6 guard pll ext ref", 8'(osc_en), 8'h14);
        pll_ref_ext = 1'b0;
        write_en(5'b00000);
        check("R6 guard pll int ref", 8'(osc_en), 8'h11);

        // R4 R9 handover back to home leaves clean pulses
        write_req(3'd0);
        cycles(SETTLE);
        check("R4 home cur_src", 8'(cur_src), 8'd0);
        mon_on = 1'b0;
        check("R9 glitch count", 8'(glitch_bad), 8'd0);

        summary();
    end
endmodule